// File: doc/BRIEF.md
# I2C Transmit Buffer Handoff

This block sits between a one-byte transmit register that the CPU writes and the output shifter of a byte-oriented I2C engine. The engine can act as master or as slave. The block decides on which acknowledge the buffered byte may be copied into the shifter, and it keeps a flag that shows whether the buffer is free. On a not-acknowledge it holds the byte back and leaves the flag clear. A master then asks for a stop or a repeated start. A slave lets go of SDA until a master addresses it again.

Bus events come from the engine as single-cycle strobes: end of the address byte and end of a data byte. The acknowledge bit is sampled on the same ninth clock. Each strobe is acted on at its rising edge only, so one acknowledge is evaluated once. The block also holds a read-only receive data register. It captures the shifter contents at the end of each received byte.

Every output is registered. A response appears in the cycle after the strobe that caused it.

Top module: `i2c_txbuf_handoff`

## Requirements
- R1: After reset, `tx_empty` is 1, `rx_data` is 0x00, and `shift_load`, `stop_rep_req` and `sda_release` are 0.
- R2: In master mode with `rw_read`=0, an address-done strobe with `ack_bit`=0 pulses `shift_load` for one cycle in the next cycle. At the same time `shift_data` takes the buffered byte and `tx_empty` goes to 1.
- R3: In master mode with `rw_read`=0, a byte-done strobe with `ack_bit`=0 loads the next buffered byte in the same way as R2.
- R4: In master mode, `ack_bit`=1 on an address-done strobe, or on a byte-done strobe while transmitting, gives no load. Instead `stop_rep_req` pulses for one cycle and `tx_empty` keeps its value. `shift_load` and `stop_rep_req` are never high together.
- R5: In slave mode with `rw_read`=1 (master reading), a byte-done strobe with `ack_bit`=1 sets `sda_release` without loading. While `sda_release` is set, further byte-done strobes load nothing.
- R6: In slave mode, an address-done strobe clears `sda_release`. With `rw_read`=1 it also loads the buffered byte as in R2.
- R7: A CPU write (`cpu_wr`=1) stores `cpu_wdata` in the buffer and clears `tx_empty`. If a load happens in the same cycle, the shifter receives the old byte and `tx_empty` ends at 0.
- R8: A strobe held high for several cycles counts as one event and produces at most one load.
- R9: A byte-done strobe in receive mode copies `shift_in` into `rx_data` in the next cycle. Receive mode is master with `rw_read`=1, or slave with `rw_read`=0. At any other time `rx_data` does not change.
- R10: While `enable`=0, no load and no request is produced, `sda_release` clears, and `rx_data` is not updated.
- R11: In master mode with `rw_read`=1, a byte-done strobe never loads the shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable |
| is_master | input | 1 | 1 = master mode, 0 = slave mode |
| rw_read | input | 1 | Transfer direction: 1 = read, 0 = write |
| addr_done | input | 1 | Strobe at the end of the address byte (ninth clock) |
| byte_done | input | 1 | Strobe at the end of a data byte (ninth clock) |
| ack_bit | input | 1 | Sampled acknowledge: 0 = ACK, 1 = NACK |
| cpu_wr | input | 1 | CPU write to the transmit buffer |
| cpu_wdata | input | 8 | Byte written by the CPU |
| shift_in | input | 8 | Byte assembled by the receive shifter |
| shift_load | output | 1 | One-cycle load pulse to the output shifter |
| shift_data | output | 8 | Byte handed to the shifter |
| tx_empty | output | 1 | Transmit buffer empty flag |
| sda_release | output | 1 | Slave asks to release SDA |
| stop_rep_req | output | 1 | Master asks for a stop or repeated start |
| rx_data | output | 8 | Read-only receive data register |

## Verification
The assertions check on every cycle the properties that hold at each clock edge:
- a not-acknowledge in master mode never leads to a load;
- a stop request appears only in master mode;
- a load leaves the empty flag set unless the CPU wrote in the same cycle;
- a disabled block stays quiet;
- each strobe edge yields a single event;
- the receive register holds its value between captures.

Only the bench's scenarios show the rest, because they depend on multi-step state:
- which byte reaches the shifter when a CPU write and a load coincide;
- that a slave stays held off until it is addressed again;
- that a held strobe gives exactly one load in total;
- that each mode and direction picks the correct action.

// File: rtl/i2c_hoff_pkg.sv
package i2c_hoff_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [BYTE_W-1:0] buf_byte;
        logic [BYTE_W-1:0] out_byte;
        logic              load;
        logic              stop_req;
        logic              release_sda;
        logic              empty;
    } tx_state_t;

    function automatic logic is_transmit(input logic master, input logic rd);
        return master ? ~rd : rd;
    endfunction
endpackage

// File: rtl/hoff_edge.sv
module hoff_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strobe,
    output logic [N-1:0] event_o
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = strobe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign event_o[i] = strobe[i] & ~prev_q[i];

        assert_single_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
            event_o[i] |=> !event_o[i]);
    end
endmodule

// File: rtl/hoff_tx_ctrl.sv
module hoff_tx_ctrl
    import i2c_hoff_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              is_master,
    input  logic              rw_read,
    input  logic              addr_ev,
    input  logic              byte_ev,
    input  logic              ack_bit,
    input  logic              cpu_wr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic              load_o,
    output logic [BYTE_W-1:0] out_byte_o,
    output logic              empty_o,
    output logic              release_o,
    output logic              stop_o
);
    tx_state_t st_d, st_q;
    logic      xmit;
    logic      do_load;

    always_comb begin
        st_d          = st_q;
        st_d.load     = 1'b0;
        st_d.stop_req = 1'b0;
        xmit          = is_transmit(is_master, rw_read);
        do_load       = 1'b0;

        if (!enable) begin
            st_d.release_sda = 1'b0;
        end else if (is_master) begin
            if (addr_ev) begin
                if (ack_bit)   st_d.stop_req = 1'b1;
                else if (xmit) do_load       = 1'b1;
            end else if (byte_ev && xmit) begin
                if (ack_bit) st_d.stop_req = 1'b1;
                else         do_load       = 1'b1;
            end
        end else begin
            if (addr_ev) begin
                st_d.release_sda = 1'b0;
                if (xmit) do_load = 1'b1;
            end else if (byte_ev && xmit && !st_q.release_sda) begin
                if (ack_bit) st_d.release_sda = 1'b1;
                else         do_load          = 1'b1;
            end
        end

        if (do_load) begin
            st_d.load     = 1'b1;
            st_d.out_byte = st_q.buf_byte;
            st_d.empty    = 1'b1;
        end

        if (cpu_wr) begin
            st_d.buf_byte = cpu_wdata;
            st_d.empty    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o     = st_q.load;
    assign out_byte_o = st_q.out_byte;
    assign empty_o    = st_q.empty;
    assign release_o  = st_q.release_sda;
    assign stop_o     = st_q.stop_req;

    assert_nack_no_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && is_master && (addr_ev || byte_ev) && ack_bit) |=> !load_o);
    assert_stop_only_master_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> $past(is_master));
    assert_load_stop_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_o, stop_o}));
    assert_held_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (release_o && enable && !is_master && !addr_ev) |=> !load_o);
    assert_load_sets_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> (empty_o || $past(cpu_wr)));
    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!load_o && !stop_o && !release_o));
    assert_master_read_no_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && rw_read && !addr_ev) |=> !load_o);
endmodule

// File: rtl/hoff_rx_reg.sv
module hoff_rx_reg
    import i2c_hoff_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              is_master,
    input  logic              rw_read,
    input  logic              byte_ev,
    input  logic [BYTE_W-1:0] shift_in,
    output logic [BYTE_W-1:0] rx_o
);
    logic [BYTE_W-1:0] rx_d, rx_q;
    logic              capture;

    always_comb begin
        capture = enable && byte_ev && !is_transmit(is_master, rw_read);
        rx_d    = capture ? shift_in : rx_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign rx_o = rx_q;

    assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(rx_q));
    assert_rx_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(rx_o));
endmodule

// File: rtl/i2c_txbuf_handoff.sv
module i2c_txbuf_handoff
    import i2c_hoff_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              is_master,
    input  logic              rw_read,
    input  logic              addr_done,
    input  logic              byte_done,
    input  logic              ack_bit,
    input  logic              cpu_wr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    input  logic [BYTE_W-1:0] shift_in,
    output logic              shift_load,
    output logic [BYTE_W-1:0] shift_data,
    output logic              tx_empty,
    output logic              sda_release,
    output logic              stop_rep_req,
    output logic [BYTE_W-1:0] rx_data
);
    localparam int NSTROBE = 2;
    localparam int IDX_ADDR = 0;
    localparam int IDX_BYTE = 1;

    logic [NSTROBE-1:0] ev;

    hoff_edge #(.N(NSTROBE)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  ({byte_done, addr_done}),
        .event_o (ev)
    );

    hoff_tx_ctrl u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .is_master  (is_master),
        .rw_read    (rw_read),
        .addr_ev    (ev[IDX_ADDR]),
        .byte_ev    (ev[IDX_BYTE]),
        .ack_bit    (ack_bit),
        .cpu_wr     (cpu_wr),
        .cpu_wdata  (cpu_wdata),
        .load_o     (shift_load),
        .out_byte_o (shift_data),
        .empty_o    (tx_empty),
        .release_o  (sda_release),
        .stop_o     (stop_rep_req)
    );

    hoff_rx_reg u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .is_master (is_master),
        .rw_read   (rw_read),
        .byte_ev   (ev[IDX_BYTE]),
        .shift_in  (shift_in),
        .rx_o      (rx_data)
    );
endmodule

// File: tb/i2c_txbuf_handoff_test.sv
module i2c_txbuf_handoff_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, is_master = 1'b0, rw_read = 1'b0;
    logic addr_done = 1'b0, byte_done = 1'b0, ack_bit = 1'b0, cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = 8'h00, shift_in = 8'h00;
    logic shift_load, tx_empty, sda_release, stop_rep_req;
    logic [7:0] shift_data, rx_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    i2c_txbuf_handoff uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .is_master(is_master),
        .rw_read(rw_read), .addr_done(addr_done), .byte_done(byte_done),
        .ack_bit(ack_bit), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .shift_in(shift_in), .shift_load(shift_load), .shift_data(shift_data),
        .tx_empty(tx_empty), .sda_release(sda_release),
        .stop_rep_req(stop_rep_req), .rx_data(rx_data)
    );

    typedef struct packed {
        logic m, rw, a, b, k, w;
        logic [7:0] wd, si;
        logic el, es, er, ee;
        logic [7:0] ed, erx;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,8'hA5,8'h00, 1'b0,1'b0,1'b0,1'b0,8'h00,8'h00},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00, 1'b1,1'b0,1'b0,1'b1,8'hA5,8'h00},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,8'h3C,8'h00, 1'b0,1'b0,1'b0,1'b0,8'h00,8'h00},
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,8'h00, 1'b1,1'b0,1'b0,1'b1,8'h3C,8'h00},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,8'h77,8'h00, 1'b0,1'b0,1'b0,1'b0,8'h00,8'h00},
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,8'h00,8'h00, 1'b0,1'b1,1'b0,1'b0,8'h00,8'h00},
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,8'h00,8'h00, 1'b0,1'b1,1'b0,1'b0,8'h00,8'h00},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00, 1'b1,1'b0,1'b0,1'b1,8'h77,8'h00},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,8'h11,8'h00, 1'b0,1'b0,1'b0,1'b0,8'h00,8'h00},
        '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,8'h00,8'h00, 1'b0,1'b0,1'b1,1'b0,8'h00,8'h00},
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,8'h00,8'h00, 1'b0,1'b0,1'b1,1'b0,8'h00,8'h00},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00, 1'b1,1'b0,1'b0,1'b1,8'h11,8'h00},
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,8'h00,8'hC3, 1'b0,1'b0,1'b0,1'b1,8'h00,8'hC3},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,8'h5A, 1'b0,1'b0,1'b0,1'b1,8'h00,8'h5A},
        '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,8'hFF, 1'b1,1'b0,1'b0,1'b1,8'h11,8'h5A}
    };

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one event at a negedge, drop strobes after the edge, sample at the next negedge.
    task automatic step(input logic m, rw, a, b, k, w, input logic [7:0] wd, si);
        @(negedge clk);
        is_master = m; rw_read = rw; addr_done = a; byte_done = b;
        ack_bit = k; cpu_wr = w; cpu_wdata = wd; shift_in = si;
        @(posedge clk);
        #1;
        addr_done = 1'b0; byte_done = 1'b0; cpu_wr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int loads;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "tx_empty", {7'd0, tx_empty}, 8'd1);
        check("R1", "rx_data", rx_data, 8'h00);
        check("R1", "outputs", {5'd0, shift_load, stop_rep_req, sda_release}, 8'd0);
        rst_n = 1'b1;
        enable = 1'b1;

        // R2 R3 R4 R5 R6 R9 R11 via the vector table
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].m, VECS[i].rw, VECS[i].a, VECS[i].b, VECS[i].k,
                 VECS[i].w, VECS[i].wd, VECS[i].si);
            check("R2/R3/R6 table", "shift_load", {7'd0, shift_load}, {7'd0, VECS[i].el});
            check("R4 table", "stop_rep_req", {7'd0, stop_rep_req}, {7'd0, VECS[i].es});
            check("R5 table", "sda_release", {7'd0, sda_release}, {7'd0, VECS[i].er});
            check("R7 table", "tx_empty", {7'd0, tx_empty}, {7'd0, VECS[i].ee});
            if (VECS[i].el) check("R2 table", "shift_data", shift_data, VECS[i].ed);
            check("R9 table", "rx_data", rx_data, VECS[i].erx);
        end

        // R8: strobe held for three cycles gives one load
        step(1, 0, 0, 0, 0, 1, 8'h42, 8'h00);
        @(negedge clk);
        is_master = 1'b1; rw_read = 1'b0; ack_bit = 1'b0; byte_done = 1'b1;
        loads = 0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            if (shift_load) loads++;
        end
        byte_done = 1'b0;
        @(negedge clk);
        if (shift_load) loads++;
        check("R8", "load count", loads[7:0], 8'd1);

        // R7: CPU write and load in the same cycle
        step(1, 0, 0, 0, 0, 1, 8'h24, 8'h00);
        step(1, 0, 0, 1, 0, 1, 8'h99, 8'h00);
        check("R7", "shift_load", {7'd0, shift_load}, 8'd1);
        check("R7", "shift_data old", shift_data, 8'h24);
        check("R7", "tx_empty", {7'd0, tx_empty}, 8'd0);
        step(1, 0, 0, 1, 0, 0, 8'h00, 8'h00);
        check("R7", "shift_data new", shift_data, 8'h99);
        check("R7", "tx_empty set", {7'd0, tx_empty}, 8'd1);

        // R10: disable clears release and blocks everything
        step(0, 1, 0, 1, 1, 0, 8'h00, 8'h00);
        check("R5", "release set", {7'd0, sda_release}, 8'd1);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check("R10", "release cleared", {7'd0, sda_release}, 8'd0);
        step(1, 0, 0, 0, 0, 1, 8'h55, 8'h00);
        step(1, 0, 1, 0, 0, 0, 8'h00, 8'h00);
        check("R10", "no load", {7'd0, shift_load}, 8'd0);
        check("R10", "tx_empty", {7'd0, tx_empty}, 8'd0);
        step(1, 0, 0, 1, 1, 0, 8'h00, 8'h00);
        check("R10", "no stop", {7'd0, stop_rep_req}, 8'd0);
        step(1, 1, 0, 1, 0, 0, 8'h00, 8'h66);
        check("R10", "rx unchanged", rx_data, 8'h5A);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule